// File: doc/BRIEF.md
# Oscillator Settling Delay Sequencer

This block keeps the internal clock of a chip disconnected, and its internal reset asserted, until the main oscillator has had time to settle. The delay comes from two 8-bit down counters joined in hardware. The first counter divides a prescaled main-clock tick. Each overflow of the first counter counts the second counter down by one. When the second counter overflows, the single output `clk_en` goes high, and the rest of the chip takes that as both clock connection and reset release.

The delay starts in one of two ways:

- **Reset.** The counters are preset and the first counter is forced onto the main clock divided by 16. Counting begins when reset is released. With the default presets the delay is 256 × 8 ticks, which is 32768 main-clock cycles.
- **Stop request.** A stop request while the clock is connected drops `clk_en` and presets the counters the same way as a reset. Nothing counts until a wake event arrives. From then on the first counter uses whatever source software has selected on `src_sel`. Software must pick the divide-by-16 source before it enters stop mode if it wants the full settling time.

Top module: `osw_ctrl`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, `clk_en` is 0 after that edge.
- R2: After `rst_n` returns high, `clk_en` rises exactly (LO_PRESET+1)·(HI_PRESET+1)·16 edges after the release, counting the first edge with `rst_n` high as edge 1. `src_sel` has no effect on this length.
- R3: Once high, `clk_en` stays high until a stop request or a reset.
- R4: `stop_req` sampled high while `clk_en` is 1 drives `clk_en` to 0 after that edge and presets both counters.
- R5: After stop entry and with no wake event, `clk_en` stays 0 however long the block waits.
- R6: After a wake edge in stop mode, `clk_en` rises exactly (LO_PRESET+1)·(HI_PRESET+1)·D edges later. D is 16 when `src_sel`=0 and 2 when `src_sel`=1.
- R7: `stop_req` during a countdown and `wake` while the clock is connected are ignored. The countdown length is unchanged, and `clk_en` stays 1.
- R8: When `rst_n` is low and `stop_req` is high at the same edge, the reset wins. After release the reset-length delay (R2) runs with no wake needed.
- R9: A reset during a stop-mode countdown abandons it and runs the reset-length delay with the divide-by-16 source, even if `src_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| stop_req | input | 1 | Request to enter stop mode |
| wake | input | 1 | Wake event; starts the stop-mode countdown |
| src_sel | input | 1 | Software-selected tick source: 0 = clk/16, 1 = clk/2 |
| clk_en | output | 1 | Internal clock enable and reset release, 1 = running |

## Verification
The hardest case to reach from the ports is a countdown that has begun but not finished, when a second event arrives. This matters both for a stop request that must be ignored and for a reset that must restart the delay on the forced source. The bench counts edges from the wake or the release and injects the competing input at a chosen edge in the middle of the countdown. It then measures the exact edge at which `clk_en` rises. Small presets keep each countdown short, so both divide ratios and both entry paths can be timed to the edge.

// File: rtl/osw_pkg.sv
package osw_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_RST_WAIT  = 2'd1,
        ST_STOP_IDLE = 2'd2,
        ST_STOP_WAIT = 2'd3
    } state_t;

    typedef struct packed {
        state_t state;
    } ctrl_t;

endpackage

// File: rtl/osw_prescaler.sv
module osw_prescaler #(
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic fast_sel,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = fast_sel ? LIM_FAST : LIM_SLOW;
        tick  = run && (pre_q == limit);
        pre_d = pre_q;
        if (clear) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = tick ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/osw_down_cnt.sv
module osw_down_cnt #(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] PRESET = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick_in,
    output logic ovf
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ovf   = tick_in && (cnt_q == '0);
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = PRESET;
        end else if (tick_in) begin
            cnt_d = (cnt_q == '0) ? PRESET : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= PRESET;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl #(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] LO_PRESET = 8'hFF,
    parameter logic [CNT_W-1:0] HI_PRESET = 8'h07,
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake,
    input  logic src_sel,
    output logic clk_en
);
    import osw_pkg::*;

    localparam int NSTAGE = 2;

    ctrl_t ctrl_d, ctrl_q;
    logic  hold;
    logic  running;
    logic  fast_sel;
    logic [NSTAGE:0] stage_tick;

    always_comb begin
        hold     = (ctrl_q.state == ST_RUN) || (ctrl_q.state == ST_STOP_IDLE);
        running  = (ctrl_q.state == ST_RST_WAIT) || (ctrl_q.state == ST_STOP_WAIT);
        fast_sel = (ctrl_q.state == ST_STOP_WAIT) && src_sel;
        ctrl_d   = ctrl_q;
        unique case (ctrl_q.state)
            ST_RUN:       if (stop_req) ctrl_d.state = ST_STOP_IDLE;
            ST_STOP_IDLE: if (wake)     ctrl_d.state = ST_STOP_WAIT;
            ST_RST_WAIT,
            ST_STOP_WAIT: if (stage_tick[NSTAGE]) ctrl_d.state = ST_RUN;
            default:      ctrl_d.state = ST_RST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q.state <= ST_RST_WAIT;
        else        ctrl_q       <= ctrl_d;
    end

    assign clk_en = (ctrl_q.state == ST_RUN);

    osw_prescaler #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hold),
        .run      (running),
        .fast_sel (fast_sel),
        .tick     (stage_tick[0])
    );

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        localparam logic [CNT_W-1:0] STAGE_PRESET = (i == 0) ? LO_PRESET : HI_PRESET;
        osw_down_cnt #(
            .CNT_W  (CNT_W),
            .PRESET (STAGE_PRESET)
        ) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (hold),
            .tick_in (stage_tick[i]),
            .ovf     (stage_tick[i+1])
        );
    end
endmodule

// File: rtl/osw_ctrl_chk.sv
module osw_ctrl_chk (
    input logic           clk,
    input logic           rst_n,
    input logic           stop_req,
    input logic           wake,
    input logic           clk_en,
    input osw_pkg::ctrl_t ctrl_q,
    input logic           last_ovf
);
    import osw_pkg::*;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!clk_en && ctrl_q.state == ST_RST_WAIT));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && last_ovf) |=> clk_en);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !stop_req) |=> clk_en);

    p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && stop_req) |=> (!clk_en && ctrl_q.state == ST_STOP_IDLE));

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_STOP_IDLE && !wake) |=> (ctrl_q.state == ST_STOP_IDLE));

    p_no_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $past(last_ovf));

    p_wait_ignores_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_STOP_WAIT && !last_ovf) |=> (ctrl_q.state == ST_STOP_WAIT));

    p_reset_prio_r8: assert property (@(posedge clk)
        (!rst_n && stop_req) |=> (ctrl_q.state == ST_RST_WAIT));
endmodule

bind osw_ctrl osw_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .wake     (wake),
    .clk_en   (clk_en),
    .ctrl_q   (ctrl_q),
    .last_ovf (stage_tick[2])
);

// File: tb/osw_ctrl_tb.sv
module osw_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LO = 8'h0F;
    localparam logic [7:0] HI = 8'h02;
    localparam int TICKS = (int'(LO) + 1) * (int'(HI) + 1);
    localparam int WATCHDOG_CYCLES = 150000;

    // [7]=stop path, [6]=src_sel, [5:0]=expected divider
    localparam logic [7:0] VEC [0:5] = '{8'h10, 8'h90, 8'hC2, 8'h50, 8'hC2, 8'h90};

    logic clk = 0;
    logic rst_n = 0;
    logic stop_req = 0;
    logic wake = 0;
    logic src_sel = 0;
    logic clk_en;
    int   checks = 0;
    int   failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osw_ctrl #(.LO_PRESET(LO), .HI_PRESET(HI)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
        .wake(wake), .src_sel(src_sel), .clk_en(clk_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts edges until clk_en rises; optional stop_req pulse at edge poke
    task automatic measure(input int exp_n, input string req, input int poke);
        int first = 0;
        for (int n = 1; n <= exp_n + 4 && first == 0; n++) begin
            @(posedge clk); #1;
            stop_req = (poke != 0 && n == poke);
            if (clk_en) first = n;
        end
        stop_req = 0;
        check(first == exp_n, req, first, exp_n);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk); rst_n = 0;
        repeat (cycles) @(posedge clk);
        #1;
        check(clk_en == 1'b0, "R1", clk_en, 0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic enter_stop();
        @(negedge clk); stop_req = 1;
        @(posedge clk); #1; stop_req = 0;
        check(clk_en == 1'b0, "R4", clk_en, 0);
    endtask

    task automatic do_wake();
        @(negedge clk); wake = 1;
        @(posedge clk); #1; wake = 0;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        src_sel = 1;
        repeat (3) @(posedge clk);
        #1;
        check(clk_en == 1'b0, "R1", clk_en, 0);
        @(negedge clk); rst_n = 1;
        measure(TICKS * 16, "R2", 0);

        for (int v = 0; v < 6; v++) begin
            src_sel = VEC[v][6];
            if (VEC[v][7]) begin
                enter_stop();
                repeat (40) @(posedge clk);
                #1;
                check(clk_en == 1'b0, "R5", clk_en, 0);
                do_wake();
                measure(TICKS * int'(VEC[v][5:0]), "R6", 0);
            end else begin
                do_reset(2);
                measure(TICKS * int'(VEC[v][5:0]), "R2", 0);
            end
        end

        // R3: stays connected; R7: wake while connected ignored
        @(negedge clk); wake = 1;
        repeat (60) @(posedge clk);
        #1; wake = 0;
        check(clk_en == 1'b1, "R3", clk_en, 1);
        check(clk_en == 1'b1, "R7", clk_en, 1);

        // R7: stop request mid-countdown does not restart
        src_sel = 1;
        enter_stop();
        do_wake();
        measure(TICKS * 2, "R7", TICKS);

        // R8: reset and stop request together
        src_sel = 1;
        @(negedge clk); rst_n = 0; stop_req = 1;
        @(posedge clk); #1;
        check(clk_en == 1'b0, "R8", clk_en, 0);
        @(negedge clk); rst_n = 1; stop_req = 0;
        measure(TICKS * 16, "R8", 0);

        // R9: reset during a fast stop-mode countdown
        src_sel = 1;
        enter_stop();
        do_wake();
        repeat (TICKS) @(posedge clk);
        do_reset(1);
        measure(TICKS * 16, "R9", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule